// File: doc/BRIEF.md
# Byte-Wide Configuration Receive Port

This block receives a configuration bitstream one byte at a time from an external host. The host uses an active-low select, an active-low write strobe and an 8-bit data bus, all sampled on the rising edge of the configuration clock. The block answers with a `busy` output. Accepted bytes are shifted into a 32-bit window. The block looks in that window for the alignment marker `32'hAA995566`. Once the marker is found, every following group of four bytes is sent to a downstream packet consumer as one word over a valid/ready handshake.

Backpressure reaches the host through `busy`. If the host changes direction while select stays low, the block treats it as an abort. A write-to-read change (the strobe is released) and a read-to-write change both count. On an abort the block throws away its alignment, keeps `busy` high for a fixed drain period, and raises a sticky abort flag. It then ignores data until a new marker arrives.

Top module: `cfg_byte_port`

## Requirements
- R1: A byte on `cfg_din` is taken at a rising edge only when `cfg_sel_n`=0, `cfg_wr_n`=0 and `busy`=0, and no abort is detected at that same edge.
- R2: `busy` is high whenever `word_ready` is low. A byte presented while `busy` is high is not taken. The same held byte is taken at the first rising edge where `busy` is low.
- R3: After alignment, each group of four accepted bytes forms one word, with the first byte in bits [31:24] and the fourth in bits [7:0]. `word_valid` rises on the clock after the fourth byte. While `word_ready` is low, `word_valid` and `word_data` stay unchanged.
- R4: When the marker `32'hAA995566` completes in the byte window, the port becomes aligned. The marker itself is never output as a word. Word grouping starts with the next accepted byte.
- R5: While the port is not aligned, accepted bytes produce no word.
- R6: If the strobe goes from 0 to 1 while select stays 0 across two consecutive edges, an abort starts at the second edge.
- R7: If the strobe goes from 1 to 0 while select stays 0 across two consecutive edges, an abort starts at that edge and the byte is not taken.
- R8: After an abort edge, `busy` is high for exactly `DRAIN_CYCLES` (default 3) clocks, then follows `word_ready` again.
- R9: An abort clears alignment and any partial word, and sets `aborted` to 1. `aborted` stays 1 until the next marker is detected. Until then no word is produced.
- R10: A synchronous active-high `rst` clears alignment, the partial word, `word_valid`, `aborted` and the drain period.
- R11: With `word_ready` held high, `busy` stays low, and a new byte can be taken on every clock with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_sel_n | input | 1 | Port select, active low |
| cfg_wr_n | input | 1 | Write strobe, active low (high = read direction) |
| cfg_din | input | 8 | Byte from host |
| busy | output | 1 | Backpressure to host |
| word_data | output | 32 | Aligned word to consumer |
| word_valid | output | 1 | Word available |
| word_ready | input | 1 | Consumer accepts word |
| aborted | output | 1 | Sticky abort indication |

## Verification
Several properties are checked on every cycle by the assertions. A stalled word stays stable. An abort edge leads to `busy` on the next cycle and to loss of alignment. A new word only appears while the port is aligned. Reset clears the outputs. Other behaviour depends on particular byte sequences and timing, so only the bench's scenarios can show it: marker recognition, byte order within a word, a held byte being taken after a stall, and the exact length of the drain. The bench follows these scenarios with a behavioural reference model that is compared on every clock.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] ALIGN_MARK = 32'hAA995566;
endpackage

// File: rtl/cfg_abort_det.sv
module cfg_abort_det #(
  parameter int unsigned DRAIN_CYCLES = 3,
  localparam int unsigned DRAIN_W = $clog2(DRAIN_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  input  logic wr_n,
  output logic abort_evt,
  output logic draining
);
  logic               sel_q;
  logic               wr_n_q;
  logic [DRAIN_W-1:0] drain_cnt;

  // direction change while select is held low across two edges
  assign abort_evt = !sel_n && sel_q && (wr_n != wr_n_q);
  assign draining  = (drain_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= 1'b0;
      wr_n_q    <= 1'b1;
      drain_cnt <= '0;
    end else begin
      sel_q  <= !sel_n;
      wr_n_q <= wr_n;
      if (abort_evt)
        drain_cnt <= DRAIN_W'(DRAIN_CYCLES);
      else if (draining)
        drain_cnt <= drain_cnt - 1'b1;
    end
  end

  // R8
  drain_len_chk: assert property (@(posedge clk) disable iff (rst)
    (draining && !abort_evt) |=> (drain_cnt == $past(drain_cnt) - 1'b1));
endmodule

// File: rtl/cfg_word_packer.sv
module cfg_word_packer
  import cfg_port_pkg::*;
#(
  parameter logic [WORD_W-1:0] MARK = ALIGN_MARK,
  localparam int unsigned BYTES = WORD_W / BYTE_W,
  localparam int unsigned CNT_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              abort,
  input  logic [BYTE_W-1:0] din,
  input  logic              word_ready,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid,
  output logic              synced,
  output logic              aborted
);
  logic [WORD_W-1:0] window;
  logic [WORD_W-1:0] window_nxt;
  logic [CNT_W-1:0]  cnt;

  assign window_nxt = {window[WORD_W-BYTE_W-1:0], din};

  always_ff @(posedge clk) begin
    if (rst) begin
      window     <= '0;
      cnt        <= '0;
      synced     <= 1'b0;
      aborted    <= 1'b0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      if (word_valid && word_ready)
        word_valid <= 1'b0;
      if (abort) begin
        window  <= '0;
        cnt     <= '0;
        synced  <= 1'b0;
        aborted <= 1'b1;
      end else if (accept) begin
        window <= window_nxt;
        if (!synced) begin
          if (window_nxt == MARK) begin
            synced  <= 1'b1;
            cnt     <= '0;
            aborted <= 1'b0;
          end
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(BYTES - 1)) begin
            word_data  <= window_nxt;
            word_valid <= 1'b1;
          end
        end
      end
    end
  end

  // R3
  hold_word_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));
  // R5
  word_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(word_valid) |-> $past(synced));
  // R9
  abort_unsync_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!synced && aborted));
endmodule

// File: rtl/cfg_byte_port.sv
module cfg_byte_port
  import cfg_port_pkg::*;
#(
  parameter int unsigned DRAIN_CYCLES = 3,
  parameter logic [WORD_W-1:0] MARK = ALIGN_MARK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_sel_n,
  input  logic              cfg_wr_n,
  input  logic [BYTE_W-1:0] cfg_din,
  output logic              busy,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid,
  input  logic              word_ready,
  output logic              aborted
);
  logic abort_evt;
  logic draining;
  logic accept;
  logic synced;

  cfg_abort_det #(.DRAIN_CYCLES(DRAIN_CYCLES)) u_abort (
    .clk      (clk),
    .rst      (rst),
    .sel_n    (cfg_sel_n),
    .wr_n     (cfg_wr_n),
    .abort_evt(abort_evt),
    .draining (draining)
  );

  assign busy   = !word_ready || draining;
  assign accept = !cfg_sel_n && !cfg_wr_n && !busy && !abort_evt;

  cfg_word_packer #(.MARK(MARK)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .abort     (abort_evt),
    .din       (cfg_din),
    .word_ready(word_ready),
    .word_data (word_data),
    .word_valid(word_valid),
    .synced    (synced),
    .aborted   (aborted)
  );

  // R8
  abort_busy_chk: assert property (@(posedge clk) disable iff (rst)
    abort_evt |=> busy);
  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!word_valid && !aborted && !synced));
endmodule

// File: tb/cfg_byte_port_bench.sv
module cfg_byte_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DRAIN = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [7:0]  din = 8'h00;
  logic        ready = 1'b1;
  logic        busy;
  logic [31:0] wdata;
  logic        wvalid;
  logic        aborted;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_byte_port #(.DRAIN_CYCLES(DRAIN)) u_cfg_byte_port (
    .clk(clk), .rst(rst), .cfg_sel_n(sel_n), .cfg_wr_n(wr_n), .cfg_din(din),
    .busy(busy), .word_data(wdata), .word_valid(wvalid), .word_ready(ready),
    .aborted(aborted)
  );

  // behavioural reference model
  bit          m_sync, m_ov, m_ab, m_psel, m_pwr;
  logic [7:0]  m_hist[$];
  logic [7:0]  m_grp[$];
  logic [31:0] m_od;
  int          m_drain;

  function automatic logic [31:0] last4();
    logic [31:0] w = 32'h0;
    foreach (m_hist[i]) w = {w[23:0], m_hist[i]};
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sync = 0; m_ov = 0; m_ab = 0; m_psel = 0; m_pwr = 1; m_drain = 0;
      m_hist.delete(); m_grp.delete(); m_od = 32'h0;
    end else begin
      bit mbusy, mab, macc;
      mbusy = !ready || (m_drain > 0);
      mab = !sel_n && m_psel && (wr_n != m_pwr);
      macc = !sel_n && !wr_n && !mbusy && !mab;
      if (m_ov && ready) m_ov = 0;
      if (mab) m_drain = DRAIN; else if (m_drain > 0) m_drain--;
      if (mab) begin
        m_sync = 0; m_ab = 1; m_hist.delete(); m_grp.delete();
      end else if (macc) begin
        m_hist.push_back(din);
        if (m_hist.size() > 4) void'(m_hist.pop_front());
        if (!m_sync) begin
          if (m_hist.size() == 4 && last4() == 32'hAA995566) begin
            m_sync = 1; m_ab = 0; m_grp.delete();
          end
        end else begin
          m_grp.push_back(din);
          if (m_grp.size() == 4) begin
            m_od = {m_grp[0], m_grp[1], m_grp[2], m_grp[3]};
            m_ov = 1; m_grp.delete();
          end
        end
      end
      m_psel = !sel_n; m_pwr = wr_n;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare();
    bit mbusy = !ready || (m_drain > 0);
    chk(busy === mbusy, "R2 busy", 32'(busy), 32'(mbusy));
    chk(wvalid === m_ov, "R3 valid", 32'(wvalid), 32'(m_ov));
    if (m_ov) chk(wdata === m_od, "R3 data", wdata, m_od);
    chk(aborted === m_ab, "R9 aborted", 32'(aborted), 32'(m_ab));
  endtask

  task automatic step(input bit s, input bit w, input logic [7:0] d, input bit r);
    @(negedge clk);
    sel_n = s; wr_n = w; din = d; ready = r;
    #1;
    if (cmp_en) compare();
  endtask

  task automatic wbyte(input logic [7:0] d);
    step(1'b0, 1'b0, d, 1'b1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 8'h00, 1'b1);
  endtask

  task automatic send_mark();
    wbyte(8'hAA); wbyte(8'h99); wbyte(8'h55); wbyte(8'h66);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; cmp_en = 1'b1;
    #1;
    // R10 reset state
    chk(wvalid === 1'b0 && aborted === 1'b0 && busy === 1'b0, "R10 reset", {29'h0, wvalid, aborted, busy}, 32'h0);

    // R5 bytes before alignment yield nothing
    for (int i = 0; i < 8; i++) wbyte(8'h10 + 8'(i));
    idle(1);
    chk(wvalid === 1'b0, "R5 unsynced", 32'(wvalid), 32'h0);

    // R4 marker not forwarded, R11 back-to-back bytes, R3 order
    send_mark();
    chk(busy === 1'b0, "R11 no busy", 32'(busy), 32'h0);
    wbyte(8'h01);
    chk(wvalid === 1'b0, "R4 marker dropped", 32'(wvalid), 32'h0);
    wbyte(8'h02); wbyte(8'h03); wbyte(8'h04);
    step(1'b0, 1'b0, 8'hA1, 1'b0);
    chk(wvalid === 1'b1 && wdata === 32'h01020304, "R3 first word", wdata, 32'h01020304);
    // R2 stall: byte held while busy
    chk(busy === 1'b1, "R2 busy on stall", 32'(busy), 32'h1);
    step(1'b0, 1'b0, 8'hA1, 1'b0);
    chk(wdata === 32'h01020304 && wvalid === 1'b1, "R3 hold", wdata, 32'h01020304);
    step(1'b0, 1'b0, 8'hA1, 1'b1);
    wbyte(8'hA2); wbyte(8'hA3); wbyte(8'hA4);
    idle(1);
    chk(wvalid === 1'b1 && wdata === 32'hA1A2A3A4, "R2 held byte taken once", wdata, 32'hA1A2A3A4);
    idle(1);
    // R1 select high: byte ignored
    step(1'b1, 1'b0, 8'hEE, 1'b1);
    wbyte(8'hB1); wbyte(8'hB2); wbyte(8'hB3); wbyte(8'hB4);
    idle(1);
    chk(wdata === 32'hB1B2B3B4, "R1 capture gate", wdata, 32'hB1B2B3B4);

    // R6 abort by strobe release
    wbyte(8'hC1); wbyte(8'hC2);
    step(1'b0, 1'b1, 8'h00, 1'b1);
    step(1'b1, 1'b1, 8'h00, 1'b1);
    chk(aborted === 1'b1, "R6 abort flag", 32'(aborted), 32'h1);
    // R8 drain length
    chk(busy === 1'b1, "R8 drain 1", 32'(busy), 32'h1);
    idle(2);
    chk(busy === 1'b1, "R8 drain 3", 32'(busy), 32'h1);
    idle(1);
    chk(busy === 1'b0, "R8 drain end", 32'(busy), 32'h0);
    // R9 no word without new marker
    for (int i = 0; i < 8; i++) wbyte(8'h20 + 8'(i));
    idle(1);
    chk(wvalid === 1'b0 && aborted === 1'b1, "R9 still aborted", {30'h0, wvalid, aborted}, 32'h1);
    send_mark();
    idle(1);
    chk(aborted === 1'b0, "R9 flag cleared", 32'(aborted), 32'h0);

    // R7 read to write switch
    step(1'b0, 1'b1, 8'h00, 1'b1);
    step(1'b0, 1'b0, 8'hD1, 1'b1);
    step(1'b1, 1'b1, 8'h00, 1'b1);
    chk(aborted === 1'b1 && busy === 1'b1, "R7 abort", {30'h0, aborted, busy}, 32'h3);
    idle(4);
    send_mark();
    wbyte(8'h5A); wbyte(8'h5B); wbyte(8'h5C); wbyte(8'h5D);
    idle(1);
    chk(wdata === 32'h5A5B5C5D, "R7 realigned", wdata, 32'h5A5B5C5D);

    // R10 mid-stream reset
    send_mark(); wbyte(8'h01);
    @(negedge clk); rst = 1'b1; cmp_en = 1'b0;
    @(negedge clk); rst = 1'b0; cmp_en = 1'b1;
    #1;
    chk(wvalid === 1'b0 && aborted === 1'b0, "R10 mid reset", {30'h0, wvalid, aborted}, 32'h0);
    wbyte(8'h02); wbyte(8'h03); wbyte(8'h04); wbyte(8'h05);
    idle(1);
    chk(wvalid === 1'b0, "R10 sync cleared", 32'(wvalid), 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule